// File: doc/BRIEF.md
# LCD Power-Up Command Sequencer

This block brings a TFT panel controller out of power-up by replaying a byte-coded command script from a ROM over an 8-bit parallel write bus. A single start pulse makes it walk the script from address 0. Plain bytes go out on the bus as write cycles, using the register-select level currently in force. Escape-coded entries are mixed in with them. These entries change chip select, set the register-select line to command or data mode, wait a number of milliseconds, pulse the panel reset low, or end the script.

A typical script does the following. It releases chip select and waits. It pulses reset twice, with a wait after each pulse. It then selects the chip and writes every 16-bit register index and value as two bytes, high byte first, with the index in command mode and the value in data mode. The visible window is set to columns 0..239 and rows 0..319. The display is switched on by writing 0x0133 to register 0x0007. After a 10 ms pause, chip select is released and the end entry follows. When the end entry is reached, `done` rises and stays high.

Timing comes from a millisecond tick made by dividing the clock by `CLKS_PER_MS`. The write strobe is low for `STROBE_W` cycles. The ROM is external and synchronous: `rom_data` shows the byte at `rom_addr` one clock after the address is presented.

Top module: `lcd_init_seq`

## Requirements
- R1: While reset is held and after it is released, with no start pulse, lcd_cs_n=1, lcd_rst_n=1, lcd_wr_n=1, lcd_rs=0 and done=0.
- R2: A start pulse while idle or done begins fetching at ROM address 0. A start pulse while the script is running is ignored.
- R3: A plain byte (any value other than 0xFF) becomes one bus write. The byte is on lcd_data for at least one cycle before lcd_wr_n falls. lcd_wr_n stays low for exactly STROBE_W cycles. lcd_data is held for one cycle after lcd_wr_n rises.
- R4: The entry 0xFF followed by 0x2m sets lcd_rs to m[0] (0 = command, 1 = data) for the bytes that follow. lcd_rs never changes while lcd_wr_n is low.
- R5: The entry 0xFF followed by 0x1n sets lcd_cs_n to the inverse of n[0]. lcd_cs_n never changes while lcd_wr_n is low.
- R6: The entry 0xFF followed by 0x3n drives lcd_rst_n low for (n*16+2) milliseconds, with at most three extra clock cycles. No write happens while lcd_rst_n is low.
- R7: The entry 0xFF followed by a byte with bit 7 set waits (byte & 0x7F) milliseconds before the next entry is acted on. No bus activity takes place during the wait.
- R8: The pair 0xFF 0xFF writes one literal 0xFF byte on the bus.
- R9: The pair 0xFF 0x00 ends the script. done goes high, no further write or reset pulse follows, and done stays high until the next start pulse, which clears it.
- R10: Bytes are written in ROM order, so a 16-bit index or value stored high byte first is sent high byte first.
- R11: An escape followed by any other command byte (0x01..0x0F or 0x40..0x7F) has no effect on the bus, lcd_rs, lcd_cs_n or lcd_rst_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse that starts the script |
| rom_addr | output | ROM_AW | Address of the script byte to read |
| rom_data | input | 8 | Script byte, valid one clock after rom_addr |
| lcd_cs_n | output | 1 | Panel chip select, active low |
| lcd_rst_n | output | 1 | Panel reset, active low |
| lcd_rs | output | 1 | Register select: 0 command, 1 data |
| lcd_wr_n | output | 1 | Write strobe, active low |
| lcd_data | output | 8 | Parallel data bus |
| done | output | 1 | High once the end entry has been reached |

## Verification
The assertions assume three things about the inputs. `start` is a synchronous signal. `rom_data` shows the byte at `rom_addr` one clock later. The script never ends with an escape byte that has no command byte after it. The done-stickiness property also takes for granted that `start` is low in the cycles it checks. The bench models the ROM as a registered read of a fixed image that ends with a well-formed end entry. It drives `start` only on falling clock edges, as single-cycle pulses. Its second mid-run pulse arrives while the script is busy, so the ignore rule is exercised without breaking those assumptions.

// File: rtl/lcd_seq_pkg.sv
// Shared constants and state types for the LCD power-up sequencer.
// Assumes the escape byte is 0xFF and command bytes follow the opcode
// layout used by lcd_seq_ctrl (upper nibble selects the action).
package lcd_seq_pkg;

    localparam logic [7:0] ESC_BYTE  = 8'hFF;
    localparam logic [7:0] END_BYTE  = 8'h00;
    localparam logic [3:0] OP_CHIP   = 4'h1;
    localparam logic [3:0] OP_MODE   = 4'h2;
    localparam logic [3:0] OP_PULSE  = 4'h3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DECODE,
        ST_WRITE,
        ST_WAIT_MS,
        ST_RST_LOW
    } seq_state_t;

    typedef enum logic [1:0] {
        WR_IDLE,
        WR_SETUP,
        WR_STROBE,
        WR_HOLD
    } wr_state_t;

endpackage

// File: rtl/lcd_ms_timer.sv
// Millisecond down-timer. A load pulse arms it with a count of
// milliseconds; one clock after count*CLKS_PER_MS cycles it pulses
// expired. A zero count expires on the cycle after the load.
// Assumes load is a single-cycle pulse and CLKS_PER_MS >= 1.
module lcd_ms_timer #(
    parameter int CLKS_PER_MS = 50000,
    parameter int MS_W        = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [MS_W-1:0] load_ms,
    output logic            expired
);

    localparam int PRE_W = $clog2(CLKS_PER_MS + 1);

    logic             running;
    logic [PRE_W-1:0] prescale;
    logic [MS_W-1:0]  ms_left;

    // Divide the clock into millisecond ticks and count them down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running  <= 1'b0;
            prescale <= '0;
            ms_left  <= '0;
            expired  <= 1'b0;
        end else begin
            expired <= 1'b0;
            if (load) begin
                if (load_ms == '0) begin
                    expired <= 1'b1;
                end else begin
                    running  <= 1'b1;
                    ms_left  <= load_ms;
                    prescale <= PRE_W'(CLKS_PER_MS - 1);
                end
            end else if (running) begin
                if (prescale == '0) begin
                    prescale <= PRE_W'(CLKS_PER_MS - 1);
                    if (ms_left == MS_W'(1)) begin
                        running <= 1'b0;
                        expired <= 1'b1;
                    end else begin
                        ms_left <= ms_left - 1'b1;
                    end
                end else begin
                    prescale <= prescale - 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/lcd_bus_writer.sv
// One parallel write cycle per go pulse: data set up one cycle, strobe
// low for STROBE_W cycles, one hold cycle, then a finished pulse.
// Assumes go arrives only while idle and STROBE_W >= 1.
module lcd_bus_writer
    import lcd_seq_pkg::*;
#(
    parameter int STROBE_W = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] byte_in,
    output logic       wr_n,
    output logic [7:0] bus_data,
    output logic       finished
);

    localparam int CNT_W = $clog2(STROBE_W + 1);

    wr_state_t        wstate;
    logic [CNT_W-1:0] width_cnt;

    // Step through setup, strobe and hold phases of a single write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wstate    <= WR_IDLE;
            width_cnt <= '0;
            wr_n      <= 1'b1;
            bus_data  <= 8'h00;
            finished  <= 1'b0;
        end else begin
            finished <= 1'b0;
            unique case (wstate)
                WR_IDLE: begin
                    if (go) begin
                        bus_data <= byte_in;
                        wstate   <= WR_SETUP;
                    end
                end
                WR_SETUP: begin
                    wr_n      <= 1'b0;
                    width_cnt <= CNT_W'(STROBE_W - 1);
                    wstate    <= WR_STROBE;
                end
                WR_STROBE: begin
                    if (width_cnt == '0) begin
                        wr_n   <= 1'b1;
                        wstate <= WR_HOLD;
                    end else begin
                        width_cnt <= width_cnt - 1'b1;
                    end
                end
                WR_HOLD: begin
                    finished <= 1'b1;
                    wstate   <= WR_IDLE;
                end
                default: wstate <= WR_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/lcd_seq_ctrl.sv
// Script walker: fetches bytes from a synchronous ROM, resolves escape
// pairs and drives chip select, register select and panel reset. Plain
// bytes are handed to the bus writer; waits and pulses use the timer.
// Assumes rom_data shows the byte at rom_addr one clock later.
module lcd_seq_ctrl
    import lcd_seq_pkg::*;
#(
    parameter int ROM_AW = 10,
    parameter int MS_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic [ROM_AW-1:0] rom_addr,
    input  logic [7:0]        rom_data,
    output logic              cs_n,
    output logic              panel_rst_n,
    output logic              rs,
    output logic              done,
    output logic              wr_go,
    output logic [7:0]        wr_byte,
    input  logic              wr_finished,
    output logic              tm_load,
    output logic [MS_W-1:0]   tm_ms,
    input  logic              tm_expired
);

    seq_state_t        state;
    logic [ROM_AW-1:0] ptr;
    logic              esc_pend;

    assign rom_addr = ptr;

    // Main sequencing: fetch, decode and wait for the engine in use.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            ptr         <= '0;
            esc_pend    <= 1'b0;
            cs_n        <= 1'b1;
            panel_rst_n <= 1'b1;
            rs          <= 1'b0;
            done        <= 1'b0;
            wr_go       <= 1'b0;
            wr_byte     <= 8'h00;
            tm_load     <= 1'b0;
            tm_ms       <= '0;
        end else begin
            wr_go   <= 1'b0;
            tm_load <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        ptr      <= '0;
                        esc_pend <= 1'b0;
                        rs       <= 1'b0;
                        done     <= 1'b0;
                        state    <= ST_FETCH;
                    end
                end
                ST_FETCH: state <= ST_DECODE;
                ST_DECODE: begin
                    ptr   <= ptr + 1'b1;
                    state <= ST_FETCH;
                    if (!esc_pend) begin
                        if (rom_data == ESC_BYTE) begin
                            esc_pend <= 1'b1;
                        end else begin
                            wr_byte <= rom_data;
                            wr_go   <= 1'b1;
                            state   <= ST_WRITE;
                        end
                    end else begin
                        esc_pend <= 1'b0;
                        if (rom_data == ESC_BYTE) begin
                            wr_byte <= ESC_BYTE;
                            wr_go   <= 1'b1;
                            state   <= ST_WRITE;
                        end else if (rom_data[7]) begin
                            tm_ms   <= MS_W'(rom_data[6:0]);
                            tm_load <= 1'b1;
                            state   <= ST_WAIT_MS;
                        end else if (rom_data == END_BYTE) begin
                            done  <= 1'b1;
                            state <= ST_IDLE;
                        end else begin
                            case (rom_data[7:4])
                                OP_CHIP: cs_n <= ~rom_data[0];
                                OP_MODE: rs   <= rom_data[0];
                                OP_PULSE: begin
                                    panel_rst_n <= 1'b0;
                                    tm_ms       <= MS_W'({rom_data[3:0], 4'b0000}) + MS_W'(2);
                                    tm_load     <= 1'b1;
                                    state       <= ST_RST_LOW;
                                end
                                default: ;
                            endcase
                        end
                    end
                end
                ST_WRITE: begin
                    if (wr_finished) state <= ST_FETCH;
                end
                ST_WAIT_MS: begin
                    if (tm_expired) state <= ST_FETCH;
                end
                ST_RST_LOW: begin
                    if (tm_expired) begin
                        panel_rst_n <= 1'b1;
                        state       <= ST_FETCH;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/lcd_init_seq.sv
// Top of the LCD power-up sequencer: the script walker, the bus write
// engine and the millisecond timer wired together. Assumes an external
// synchronous ROM with one clock of read latency.
module lcd_init_seq #(
    parameter int CLKS_PER_MS = 50000,
    parameter int STROBE_W    = 2,
    parameter int ROM_AW      = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic [ROM_AW-1:0] rom_addr,
    input  logic [7:0]        rom_data,
    output logic              lcd_cs_n,
    output logic              lcd_rst_n,
    output logic              lcd_rs,
    output logic              lcd_wr_n,
    output logic [7:0]        lcd_data,
    output logic              done
);

    localparam int MS_W = 8;

    logic            wr_go;
    logic [7:0]      wr_byte;
    logic            wr_finished;
    logic            tm_load;
    logic [MS_W-1:0] tm_ms;
    logic            tm_expired;

    lcd_seq_ctrl #(
        .ROM_AW (ROM_AW),
        .MS_W   (MS_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .rom_addr    (rom_addr),
        .rom_data    (rom_data),
        .cs_n        (lcd_cs_n),
        .panel_rst_n (lcd_rst_n),
        .rs          (lcd_rs),
        .done        (done),
        .wr_go       (wr_go),
        .wr_byte     (wr_byte),
        .wr_finished (wr_finished),
        .tm_load     (tm_load),
        .tm_ms       (tm_ms),
        .tm_expired  (tm_expired)
    );

    lcd_bus_writer #(
        .STROBE_W (STROBE_W)
    ) u_writer (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (wr_go),
        .byte_in  (wr_byte),
        .wr_n     (lcd_wr_n),
        .bus_data (lcd_data),
        .finished (wr_finished)
    );

    lcd_ms_timer #(
        .CLKS_PER_MS (CLKS_PER_MS),
        .MS_W        (MS_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tm_load),
        .load_ms (tm_ms),
        .expired (tm_expired)
    );

endmodule

// File: rtl/lcd_init_seq_chk.sv
// Protocol checker for lcd_init_seq, attached with bind. Assumes start
// is synchronous and the ROM image ends with a complete end entry.
module lcd_init_seq_chk #(
    parameter int STROBE_W = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       lcd_cs_n,
    input logic       lcd_rst_n,
    input logic       lcd_rs,
    input logic       lcd_wr_n,
    input logic [7:0] lcd_data,
    input logic       done
);

    localparam int LOW_W = $clog2(STROBE_W + 2) + 1;

    logic [LOW_W-1:0] low_cnt;

    // Count consecutive cycles with the strobe low.
    always_ff @(posedge clk) begin
        if (!rst_n)        low_cnt <= '0;
        else if (!lcd_wr_n) low_cnt <= low_cnt + 1'b1;
        else               low_cnt <= '0;
    end

    p_setup_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lcd_wr_n) |-> $stable(lcd_data));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lcd_wr_n) |=> (lcd_wr_n && $stable(lcd_data)));

    p_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lcd_wr_n) |-> (low_cnt == LOW_W'(STROBE_W)));

    p_rs_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!lcd_wr_n && !$fell(lcd_wr_n)) |-> $stable(lcd_rs));

    p_cs_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!lcd_wr_n && !$fell(lcd_wr_n)) |-> $stable(lcd_cs_n));

    p_quiet_in_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !lcd_rst_n |-> lcd_wr_n);

    p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lcd_wr_n && lcd_rst_n));

    p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

endmodule

bind lcd_init_seq lcd_init_seq_chk #(.STROBE_W(STROBE_W)) i_lcd_init_seq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .lcd_cs_n  (lcd_cs_n),
    .lcd_rst_n (lcd_rst_n),
    .lcd_rs    (lcd_rs),
    .lcd_wr_n  (lcd_wr_n),
    .lcd_data  (lcd_data),
    .done      (done)
);

// File: tb/test_lcd_init_seq.sv
`timescale 1ns/1ps
module test_lcd_init_seq;

    localparam int CPM   = 4;
    localparam int SW    = 2;
    localparam int AW    = 10;
    localparam int NROM  = 56;
    localparam int NWR   = 17;

    // Script image: escape 0xFF, then 1n chip, 2m mode, 3n pulse, 8x+ wait, 00 end.
    localparam logic [7:0] ROM_IMG [0:NROM-1] = '{
        8'hFF, 8'h10, 8'hFF, 8'h85, 8'hFF, 8'h30, 8'hFF, 8'h85,
        8'hFF, 8'h31, 8'hFF, 8'h85, 8'hFF, 8'h11, 8'hFF, 8'h20,
        8'h00, 8'h50, 8'hFF, 8'h21, 8'h00, 8'h00, 8'hFF, 8'h20,
        8'h00, 8'h51, 8'hFF, 8'h21, 8'h00, 8'hEF, 8'hFF, 8'h20,
        8'h00, 8'h53, 8'hFF, 8'h21, 8'h01, 8'h3F, 8'hFF, 8'h20,
        8'h00, 8'h07, 8'hFF, 8'h21, 8'h01, 8'h33, 8'hFF, 8'h8A,
        8'hFF, 8'h47, 8'hFF, 8'hFF, 8'hFF, 8'h10, 8'hFF, 8'h00
    };

    // Expected writes as {rs, data}.
    localparam logic [8:0] EXP_WR [0:NWR-1] = '{
        9'h000, 9'h050, 9'h100, 9'h100, 9'h000, 9'h051, 9'h100, 9'h1EF,
        9'h000, 9'h053, 9'h101, 9'h13F, 9'h000, 9'h007, 9'h101, 9'h133,
        9'h1FF
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] rom_addr;
    logic [7:0]    rom_data = 8'h00;
    logic          lcd_cs_n, lcd_rst_n, lcd_rs, lcd_wr_n, done;
    logic [7:0]    lcd_data;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    always @(posedge clk)
        rom_data <= (int'(rom_addr) < NROM) ? ROM_IMG[rom_addr] : 8'h00;

    lcd_init_seq #(.CLKS_PER_MS(CPM), .STROBE_W(SW), .ROM_AW(AW)) i_lcd_init_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .rom_addr(rom_addr),
        .rom_data(rom_data), .lcd_cs_n(lcd_cs_n), .lcd_rst_n(lcd_rst_n),
        .lcd_rs(lcd_rs), .lcd_wr_n(lcd_wr_n), .lcd_data(lcd_data), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    // Bus and reset monitor, sampled on falling edges.
    int   cyc = 0, ncap = 0, nrst = 0, nfall = 0, lowcnt = 0, rlow = 0;
    logic cap_rs [0:63];
    logic cap_cs [0:63];
    logic [7:0] cap_data [0:63];
    int   rise_cyc [0:63];
    int   rst_w [0:7];
    int   rst_rise_cyc [0:7];
    int   rst_fall_cyc [0:7];
    logic prev_wr = 1'b1, prev_rst = 1'b1, hold_pend = 1'b0;
    logic [7:0] prev_data = 8'h00, hold_data = 8'h00;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (hold_pend) begin
                chk(lcd_wr_n && lcd_data == hold_data, "R3 hold", lcd_data, hold_data);
                hold_pend = 1'b0;
            end
            if (prev_wr && !lcd_wr_n)
                chk(lcd_data == prev_data, "R3 setup", lcd_data, prev_data);
            if (!lcd_wr_n) lowcnt++;
            if (!prev_wr && lcd_wr_n && ncap < 64) begin
                chk(lowcnt == SW, "R3 strobe width", lowcnt, SW);
                cap_rs[ncap]   = lcd_rs;
                cap_cs[ncap]   = lcd_cs_n;
                cap_data[ncap] = lcd_data;
                rise_cyc[ncap] = cyc;
                ncap++;
                hold_pend = 1'b1;
                hold_data = lcd_data;
                lowcnt = 0;
            end
            if (!lcd_rst_n) rlow++;
            if (prev_rst && !lcd_rst_n && nfall < 8) begin
                rst_fall_cyc[nfall] = cyc;
                nfall++;
            end
            if (!prev_rst && lcd_rst_n && nrst < 8) begin
                rst_w[nrst] = rlow;
                rst_rise_cyc[nrst] = cyc;
                nrst++;
                rlow = 0;
            end
        end
        prev_wr   = lcd_wr_n;
        prev_data = lcd_data;
        prev_rst  = lcd_rst_n;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R9 watchdog: actual 20000 cycles expected done earlier");
        report();
        $finish;
    end

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic check_run(input int base);
        for (int k = 0; k < NWR; k++) begin
            chk({cap_rs[base+k], cap_data[base+k]} == EXP_WR[k],
                (k == NWR-1) ? "R8 literal escape" : "R4/R10 write order",
                int'({cap_rs[base+k], cap_data[base+k]}), int'(EXP_WR[k]));
            chk(cap_cs[base+k] == 1'b0, "R5 chip selected during write",
                cap_cs[base+k], 0);
        end
    endtask

    initial begin
        // R1: reset state while held in reset.
        repeat (3) @(negedge clk);
        chk({lcd_cs_n, lcd_rst_n, lcd_wr_n, lcd_rs, done} == 5'b11100, "R1 in reset",
            {lcd_cs_n, lcd_rst_n, lcd_wr_n, lcd_rs, done}, 5'b11100);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        chk({lcd_cs_n, lcd_rst_n, lcd_wr_n, lcd_rs, done} == 5'b11100, "R1 idle",
            {lcd_cs_n, lcd_rst_n, lcd_wr_n, lcd_rs, done}, 5'b11100);

        // Run 1.
        pulse_start();
        chk(rom_addr == '0, "R2 fetch from 0", rom_addr, 0);
        while (!done) @(negedge clk);
        chk(ncap == NWR, "R11 write count", ncap, NWR);
        check_run(0);
        chk(nrst == 2, "R6 pulse count", nrst, 2);
        chk(rst_w[0] >= 2*CPM && rst_w[0] <= 2*CPM+3, "R6 pulse n=0", rst_w[0], 2*CPM);
        chk(rst_w[1] >= 18*CPM && rst_w[1] <= 18*CPM+3, "R6 pulse n=1", rst_w[1], 18*CPM);
        chk(rst_fall_cyc[1] - rst_rise_cyc[0] >= 5*CPM &&
            rst_fall_cyc[1] - rst_rise_cyc[0] <= 5*CPM+14, "R7 wait 5 ms",
            rst_fall_cyc[1] - rst_rise_cyc[0], 5*CPM);
        chk(rise_cyc[16] - rise_cyc[15] >= 10*CPM &&
            rise_cyc[16] - rise_cyc[15] <= 10*CPM+24, "R7 wait 10 ms",
            rise_cyc[16] - rise_cyc[15], 10*CPM);
        chk(lcd_cs_n == 1'b1, "R5 released at end", lcd_cs_n, 1);

        // R9: done is sticky and the bus stays quiet.
        repeat (40) @(negedge clk);
        chk(done == 1'b1, "R9 done held", done, 1);
        chk(ncap == NWR && nrst == 2, "R9 no activity after end", ncap, NWR);

        // Run 2 with a start pulse mid-run that must be ignored.
        pulse_start();
        @(negedge clk);
        chk(done == 1'b0, "R9 start clears done", done, 0);
        repeat (60) @(negedge clk);
        chk(done == 1'b0, "R2 still running", done, 0);
        pulse_start();
        while (!done) @(negedge clk);
        chk(ncap == 2*NWR, "R2 restart ignored write count", ncap, 2*NWR);
        chk(nrst == 4, "R2 restart ignored pulse count", nrst, 4);
        check_run(NWR);

        report();
        $finish;
    end

endmodule